// File: doc/BRIEF.md
# Interval Timer Counter Readback Interface

This block is the host-facing access path for a set of 16-bit down-counters. An 8-bit bus with a two-bit address, a read strobe and a write strobe reaches one data port per counter and a shared command port. The command port takes three kinds of byte:

- A setup word, which sets a counter's access mode, its counting-mode field and its BCD flag.
- A single-counter freeze command.
- A multi-counter snapshot command, which can capture counts, status bytes, or both, for any subset of the counters in one cycle.

Each counter has a load state machine that handles byte-wise loading, transfer into the counting element and null-count tracking. Each counter also has a read state machine that sequences bytes out of either the live count or a frozen copy. A counter decrements on a cycle where its tick input and its gate input are both high, stops at zero and raises its output pin there. The mode and BCD fields are only stored and reported.

Load state machine (per counter):

- EMPTY (after reset or a setup word) goes to PEND on a single-byte load, or to HALF on a low byte in word mode.
- HALF goes to PEND on the high byte.
- PEND goes to RUN on the first tick, when the new value is copied in.
- RUN goes to PEND or HALF when a new load starts.
- A setup word returns any state to EMPTY.

Read state machine (per counter):

- LIVE_LO goes to LIVE_HI on a word-mode read, and to HELD_LO on a freeze.
- LIVE_HI goes to LIVE_LO on a read, and to HELD_HI on a freeze.
- HELD_LO goes to HELD_HI on a word-mode read, and to LIVE_LO on a single-byte read.
- HELD_HI goes to LIVE_LO on a read.
- A setup word returns any state to LIVE_LO.

A captured status byte sits in a separate flag beside this machine. While that flag is set, the next read returns the status byte and the machine does not move.

Top module: `tmr_rdbk_if`

## Requirements
- R1: After reset every counter holds count 0, its output pin is low, null count is 1, and its access mode is word (low byte then high byte), with mode and BCD fields 0.
- R2: A command-port write with bits 5:4 = 00 freezes the selected counter's current count (bits 7:6 select counter 0..2). The counter keeps counting, and reads return the frozen value until it has been fully read.
- R3: While a frozen count has not been fully read, further freeze commands to that counter have no effect.
- R4: Access mode is bits 5:4 of the setup word. 01 reads and loads the low byte only (a load sets the high byte to 0). 10 reads and loads the high byte only (a load sets the low byte to 0). 11 alternates low byte then high byte on both reads and loads.
- R5: A setup word resets both byte sequences of its counter to the low byte, sets null count, clears the output pin and discards any frozen count or status.
- R6: A command byte with bits 7:6 = 11 and bit 0 = 0 is a snapshot command. Bit 5 = 0 captures counts, bit 4 = 0 captures status bytes, and bits 1, 2 and 3 select counters 0, 1 and 2. All selected counters are captured in the same cycle, and unselected counters are untouched.
- R7: The status byte holds, from bit 7 down: output pin, null count, access mode (2 bits), mode (3 bits), BCD flag.
- R8: When both status and count are captured, the first read returns the status byte and the following reads return the count bytes in access-mode order.
- R9: Null count goes to 1 when a load completes and back to 0 on the first tick after it, when the new count is copied in. Before that copy, reads return the previous count.
- R10: A running counter decrements by one on each tick while its gate is high, and holds while its gate is low.
- R11: The output pin goes high when the count reaches zero, and the count then stays at zero. Copying in a nonzero count brings the pin low again.
- R12: A captured status byte is frozen until it is read; further status captures for that counter are ignored until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port select: 0..2 counter data ports, 3 command port |
| rd_stb | input | 1 | Read strobe, one cycle per byte |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port while rd_stb is high |
| cnt_tick | input | 3 | Per-counter count enable (counter clock edge) |
| gate | input | 3 | Per-counter gate; counting only while high |
| out_pin | output | 3 | Per-counter output, high at terminal count |

## Verification
The bench builds the block with its default of three counters and a two-bit address. That width reaches every counter-select bit of the snapshot command and a subset selection that skips the middle counter. The three counters are put into different access modes, so word, low-only and high-only reads run in parallel under a single snapshot. A scoreboard queue of expected bytes covers status-before-count ordering, freeze persistence across ticks, and reads taken before a pending count is copied in.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'b00,
        ACC_LSB    = 2'b01,
        ACC_MSB    = 2'b10,
        ACC_WORD   = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_t;

    typedef enum logic [1:0] {
        LD_EMPTY = 2'b00,
        LD_HALF  = 2'b01,
        LD_PEND  = 2'b10,
        LD_RUN   = 2'b11
    } ld_e;

    typedef enum logic [1:0] {
        RP_LIVE_LO = 2'b00,
        RP_LIVE_HI = 2'b01,
        RP_HELD_LO = 2'b10,
        RP_HELD_HI = 2'b11
    } rp_e;
endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
    import tmr_pkg::*;
#(
    parameter int N_CNT  = 3,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [N_CNT-1:0]  ctl_wr,
    output logic [N_CNT-1:0]  frz_cmd,
    output logic [N_CNT-1:0]  sta_cmd,
    output logic [N_CNT-1:0]  data_wr,
    output logic [N_CNT-1:0]  data_rd
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_CNT);

    logic       cmd_wr;
    logic [1:0] sel;
    logic       snap;

    assign cmd_wr = wr_stb && (addr == CTL_ADDR);
    assign sel    = wdata[7:6];
    assign snap   = (sel == 2'b11) && !wdata[0];

    for (genvar i = 0; i < N_CNT; i++) begin : g_dec
        logic own;
        assign own        = cmd_wr && (sel == 2'(i));
        assign ctl_wr[i]  = own && (wdata[5:4] != 2'b00);
        assign frz_cmd[i] = (own && (wdata[5:4] == 2'b00)) ||
                            (cmd_wr && snap && !wdata[5] && wdata[i+1]);
        assign sta_cmd[i] = cmd_wr && snap && !wdata[4] && wdata[i+1];
        assign data_wr[i] = wr_stb && (addr == ADDR_W'(i));
        assign data_rd[i] = rd_stb && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  ctrl_t             ctl_in,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              tick,
    input  logic              gate,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  cur_q,
    output logic              null_q,
    output logic              out_q
);
    ld_e              state_q, state_d;
    logic [CNT_W-1:0] cr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_EMPTY;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            state_d = LD_EMPTY;
        end else if (data_wr) begin
            unique case (ctrl_q.acc)
                ACC_WORD: state_d = (state_q == LD_HALF) ? LD_PEND : LD_HALF;
                ACC_LSB, ACC_MSB, ACC_FREEZE: state_d = LD_PEND;
            endcase
        end else begin
            unique case (state_q)
                LD_PEND: if (tick) state_d = LD_RUN;
                LD_EMPTY, LD_HALF, LD_RUN: state_d = state_q;
            endcase
        end
    end

    assign null_q = (state_q != LD_RUN);

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{acc: ACC_WORD, mode: 3'b000, bcd: 1'b0};
            cr_q   <= '0;
            cur_q  <= '0;
            out_q  <= 1'b0;
        end else if (ctl_wr) begin
            ctrl_q <= ctl_in;
            out_q  <= 1'b0;
        end else if (data_wr) begin
            unique case (ctrl_q.acc)
                ACC_LSB: cr_q <= {{BYTE_W{1'b0}}, wbyte};
                ACC_MSB: cr_q <= {wbyte, {BYTE_W{1'b0}}};
                ACC_WORD, ACC_FREEZE: begin
                    if (state_q == LD_HALF) cr_q[CNT_W-1:BYTE_W] <= wbyte;
                    else                    cr_q[BYTE_W-1:0]     <= wbyte;
                end
            endcase
        end else if (state_q == LD_PEND && tick) begin
            cur_q <= cr_q;
            out_q <= (cr_q == '0);
        end else if (state_q == LD_RUN && tick && gate && cur_q != '0) begin
            cur_q <= cur_q - CNT_W'(1);
            if (cur_q == CNT_W'(1)) out_q <= 1'b1;
        end
    end

    assert_out_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> (cur_q == '0));

    assert_setup_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr) |-> (null_q && !out_q));

    assert_copy_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == LD_PEND) && $past(tick) && !$past(ctl_wr) && !$past(data_wr))
        |-> (!null_q && cur_q == $past(cr_q)));

    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == LD_RUN) && !$past(gate) && !$past(ctl_wr) && !$past(data_wr))
        |-> (cur_q == $past(cur_q)));
endmodule

// File: rtl/tmr_rd_path.sv
module tmr_rd_path
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  acc_e              acc,
    input  logic              frz_cmd,
    input  logic              sta_cmd,
    input  logic              data_rd,
    input  logic [CNT_W-1:0]  cur,
    input  logic [BYTE_W-1:0] sta_now,
    output logic [BYTE_W-1:0] rd_byte
);
    rp_e               state_q, state_d;
    logic [CNT_W-1:0]  hold_q;
    logic              sta_q;
    logic [BYTE_W-1:0] sta_byte_q;
    logic              held;
    logic              cnt_rd;

    assign held   = (state_q == RP_HELD_LO) || (state_q == RP_HELD_HI);
    assign cnt_rd = data_rd && !sta_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RP_LIVE_LO;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            state_d = RP_LIVE_LO;
        end else begin
            unique case (state_q)
                RP_LIVE_LO: begin
                    if (frz_cmd)                        state_d = RP_HELD_LO;
                    else if (cnt_rd && acc == ACC_WORD) state_d = RP_LIVE_HI;
                end
                RP_LIVE_HI: begin
                    if (frz_cmd)     state_d = RP_HELD_HI;
                    else if (cnt_rd) state_d = RP_LIVE_LO;
                end
                RP_HELD_LO: begin
                    if (cnt_rd) state_d = (acc == ACC_WORD) ? RP_HELD_HI : RP_LIVE_LO;
                end
                RP_HELD_HI: begin
                    if (cnt_rd) state_d = RP_LIVE_LO;
                end
            endcase
        end
    end

    // frozen copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            sta_q      <= 1'b0;
            sta_byte_q <= '0;
        end else if (ctl_wr) begin
            sta_q <= 1'b0;
        end else begin
            if (frz_cmd && !held) hold_q <= cur;
            if (sta_cmd && !sta_q) begin
                sta_q      <= 1'b1;
                sta_byte_q <= sta_now;
            end else if (data_rd && sta_q) begin
                sta_q <= 1'b0;
            end
        end
    end

    // output byte select
    always_comb begin
        logic [CNT_W-1:0] src;
        logic             hi_sel;
        src = held ? hold_q : cur;
        unique case (acc)
            ACC_MSB:  hi_sel = 1'b1;
            ACC_WORD: hi_sel = (state_q == RP_LIVE_HI) || (state_q == RP_HELD_HI);
            ACC_LSB, ACC_FREEZE: hi_sel = 1'b0;
        endcase
        if (sta_q)       rd_byte = sta_byte_q;
        else if (hi_sel) rd_byte = src[CNT_W-1:BYTE_W];
        else             rd_byte = src[BYTE_W-1:0];
    end

    assert_seq_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_WORD) |-> (state_q == RP_LIVE_LO || state_q == RP_HELD_LO));

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held) && !$past(ctl_wr)) |-> $stable(hold_q));

    assert_status_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(data_rd) && $past(sta_q) && !$past(ctl_wr) && !$past(frz_cmd))
        |-> (state_q == $past(state_q)));

    assert_status_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sta_q) && !$past(data_rd) && !$past(ctl_wr))
        |-> (sta_q && $stable(sta_byte_q)));
endmodule

// File: rtl/tmr_rdbk_if.sv
module tmr_rdbk_if
    import tmr_pkg::*;
#(
    parameter  int N_CNT  = 3,
    localparam int ADDR_W = $clog2(N_CNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [N_CNT-1:0]  cnt_tick,
    input  logic [N_CNT-1:0]  gate,
    output logic [N_CNT-1:0]  out_pin
);
    logic [N_CNT-1:0]  ctl_wr, frz_cmd, sta_cmd, data_wr, data_rd;
    logic [BYTE_W-1:0] rd_byte [N_CNT];

    tmr_bus_dec #(.N_CNT(N_CNT), .ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .wdata   (wdata),
        .ctl_wr  (ctl_wr),
        .frz_cmd (frz_cmd),
        .sta_cmd (sta_cmd),
        .data_wr (data_wr),
        .data_rd (data_rd)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  cur;
        logic              nul;
        logic              outq;

        tmr_cnt_core u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (ctl_wr[i]),
            .ctl_in  (ctrl_t'(wdata[5:0])),
            .data_wr (data_wr[i]),
            .wbyte   (wdata),
            .tick    (cnt_tick[i]),
            .gate    (gate[i]),
            .ctrl_q  (ctrl),
            .cur_q   (cur),
            .null_q  (nul),
            .out_q   (outq)
        );

        tmr_rd_path u_rd (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (ctl_wr[i]),
            .acc     (ctrl.acc),
            .frz_cmd (frz_cmd[i]),
            .sta_cmd (sta_cmd[i]),
            .data_rd (data_rd[i]),
            .cur     (cur),
            .sta_now ({outq, nul, ctrl}),
            .rd_byte (rd_byte[i])
        );

        assign out_pin[i] = outq;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (addr == ADDR_W'(i)) rdata = rd_byte[i];
        end
    end
endmodule

// File: tb/test_tmr_rdbk_if.sv
`timescale 1ns/1ps
module test_tmr_rdbk_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] cnt_tick = '0;
    logic [2:0] gate = 3'b111;
    logic [2:0] out_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    tmr_rdbk_if i_tmr_rdbk_if (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wdata(wdata), .rdata(rdata), .cnt_tick(cnt_tick), .gate(gate), .out_pin(out_pin)
    );

    // monitor: compares each read byte against the scoreboard
    always @(negedge clk) begin
        if (rd_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard actual=%02h expected=none", rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%02h expected=%02h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_stb = 1'b1;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        addr = a; rd_stb = 1'b1;
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic tk(input logic [2:0] m, input int n);
        @(posedge clk); #1;
        cnt_tick = m;
        repeat (n) @(posedge clk);
        #1 cnt_tick = '0;
    endtask

    task automatic chk_pin(input string t, input logic [2:0] e);
        @(negedge clk);
        checks++;
        if (out_pin !== e) begin
            errors++;
            $display("FAIL %s actual=%03b expected=%03b", t, out_pin, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            if (exp_q.size() != 0) begin
                errors++;
                $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
            end
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R7 status layout
        chk_pin("R1 out after reset", 3'b000);
        wr(2'd3, 8'hEE);
        rd(2'd0, 8'h70, "R1 R7 status c0");
        rd(2'd1, 8'h70, "R1 R7 status c1");
        rd(2'd2, 8'h70, "R1 R7 status c2");
        rd(2'd0, 8'h00, "R1 count lo");
        rd(2'd0, 8'h00, "R1 count hi");

        // R9 null count before copy-in
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h34);
        wr(2'd0, 8'h12);
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'h74, "R9 R7 status pending");
        rd(2'd0, 8'h00, "R9 old count lo");
        rd(2'd0, 8'h00, "R9 old count hi");

        // R2 freeze while counting
        tk(3'b001, 5);
        wr(2'd3, 8'h00);
        tk(3'b001, 5);
        rd(2'd0, 8'h30, "R2 frozen lo");
        tk(3'b001, 3);
        rd(2'd0, 8'h12, "R2 frozen hi");
        rd(2'd0, 8'h28, "R10 R2 live lo");
        rd(2'd0, 8'h12, "R10 R2 live hi");

        // R3 repeated freeze ignored
        wr(2'd3, 8'h00);
        tk(3'b001, 2);
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h28, "R3 first freeze lo");
        rd(2'd0, 8'h12, "R3 first freeze hi");
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h26, "R3 refreeze lo");
        rd(2'd0, 8'h12, "R3 refreeze hi");

        // R10 gate low holds
        gate = 3'b110;
        tk(3'b001, 5);
        gate = 3'b111;
        rd(2'd0, 8'h26, "R10 gate low lo");
        rd(2'd0, 8'h12, "R10 gate low hi");

        // R5 setup word resets sequence and drops freeze
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h26, "R5 half read");
        wr(2'd3, 8'h34);
        rd(2'd0, 8'h26, "R5 seq back to lo");
        rd(2'd0, 8'h12, "R5 hi after lo");
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'h74, "R5 null set");

        // R4 single-byte access modes
        wr(2'd3, 8'h51);
        wr(2'd1, 8'hAB);
        tk(3'b010, 1);
        rd(2'd1, 8'hAB, "R4 lsb only");
        rd(2'd1, 8'hAB, "R4 lsb no alternation");
        wr(2'd3, 8'hA0);
        wr(2'd2, 8'h56);
        tk(3'b100, 1);
        rd(2'd2, 8'h56, "R4 msb only");
        rd(2'd2, 8'h56, "R4 msb no alternation");
        wr(2'd3, 8'hE4);
        rd(2'd1, 8'h11, "R7 status lsb bcd");

        // R6 snapshot of all counters, then a subset
        wr(2'd0, 8'h05);
        wr(2'd0, 8'h00);
        tk(3'b001, 1);
        wr(2'd3, 8'hDE);
        tk(3'b111, 2);
        rd(2'd0, 8'h05, "R6 snap c0 lo");
        rd(2'd0, 8'h00, "R6 snap c0 hi");
        rd(2'd1, 8'hAB, "R6 snap c1");
        rd(2'd2, 8'h56, "R6 snap c2");
        wr(2'd3, 8'hDA);
        tk(3'b111, 1);
        rd(2'd1, 8'hA8, "R6 unselected live");
        rd(2'd0, 8'h03, "R6 subset c0 lo");
        rd(2'd0, 8'h00, "R6 subset c0 hi");
        rd(2'd2, 8'h55, "R6 subset c2");

        // R8 status first, then count
        wr(2'd3, 8'hC2);
        rd(2'd0, 8'h34, "R8 status first");
        rd(2'd0, 8'h02, "R8 count lo");
        rd(2'd0, 8'h00, "R8 count hi");

        // R11 terminal count
        tk(3'b001, 2);
        chk_pin("R11 out high at zero", 3'b001);
        tk(3'b001, 2);
        rd(2'd0, 8'h00, "R11 stays zero lo");
        rd(2'd0, 8'h00, "R11 stays zero hi");
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'hB4, "R11 R7 status out");
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h00);
        tk(3'b001, 1);
        chk_pin("R11 out low after reload", 3'b000);

        // R12 status held; R9 read before copy-in
        wr(2'd3, 8'hE4);
        wr(2'd1, 8'h10);
        wr(2'd3, 8'hE4);
        rd(2'd1, 8'h11, "R12 first status kept");
        rd(2'd1, 8'hA8, "R9 old count before tick");
        tk(3'b010, 1);
        rd(2'd1, 8'h10, "R9 new count after tick");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule